// File: doc/BRIEF.md
# Beam-Synchronous Sample Fanout Buffers

This block takes one device sample per beam pulse, together with a vector of per-definition event bits for that pulse. It fans the sample out to a set of independent capture buffers, one for each acquisition definition. A buffer takes part in a pulse only when its own event bit is set. Each buffer first accumulates a programmed number of accepted samples. It then stores their integer mean as one measurement, and it stops once it holds its programmed number of measurements.

The buffers share one storage array. A sequencer visits the buffers one per clock cycle after each accepted sample, so one pulse costs `NB` cycles. That is a tiny fraction of a beam-pulse period. Software-side logic programs each buffer's averaging and measurement counts, clears buffers, and reads stored measurements back through a read port. It can watch per-buffer fill counts and done flags at all times. The deployed capacity is 2800 measurements per buffer. The elaboration default of `DEPTH` is smaller, to keep the default memory compact.

Top module: `bsa_fanout`

## Requirements
- R1: After reset every fill count is 0, every done flag is 0 and `busy` is 0.
- R2: On a pulse, a buffer whose event bit in `smp_ev` (bit b for buffer b) is 0 keeps its fill count, done flag and partial sum unchanged.
- R3: A buffer with averaging count N stores floor(sum/N) of its last N accepted samples as one measurement, then restarts its sum. An averaging count of 0 is treated as 1.
- R4: When a buffer's fill count reaches its measurement count, its done flag rises. Until the buffer is cleared, further pulses leave its fill count and stored data unchanged.
- R5: A measurement count of 0, or one larger than `DEPTH`, is treated as `DEPTH`. No buffer ever holds more than `DEPTH` measurements.
- R6: A buffer whose bit is set in `clr_mask` for one cycle returns to fill 0 and done 0, and any partial sum in progress is discarded.
- R7: An accepted sample (`smp_valid` while `busy` is 0) raises `busy` for exactly `NB` cycles. A sample presented while `busy` is 1 is ignored.
- R8: `rd_data` returns, one cycle after `rd_idx`/`rd_addr` are applied, measurement number `rd_addr` (0 = first stored) of buffer `rd_idx`.
- R9: Each buffer uses only its own averaging and measurement counts, written through `cfg_we` with `cfg_idx` selecting the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe: a pulse's sample is present |
| smp_data | input | DW | Device sample, unsigned |
| smp_ev | input | NB | Event bits of the pulse, bit b gates buffer b |
| cfg_we | input | 1 | Write the counts of one buffer |
| cfg_idx | input | IW | Buffer selected for the configuration write |
| cfg_avg | input | AW | Samples averaged per measurement (0 means 1) |
| cfg_meas | input | PW | Measurements to store (0 or above DEPTH means DEPTH) |
| clr_mask | input | NB | Clear the buffers whose bits are set |
| rd_idx | input | IW | Buffer to read |
| rd_addr | input | PW | Measurement number to read |
| rd_data | output | DW | Stored measurement, one cycle latency |
| fill_cnt | output | NB*PW | Per-buffer fill counts, buffer b at bits b*PW upward |
| done | output | NB | Per-buffer done flags |
| busy | output | 1 | Sequencer is distributing the current sample |

## Verification
A wrong per-buffer pointer or done flag shows at the ports within one pulse: the fill count of that buffer departs from the expected value once `busy` falls. A corrupted partial sum stays hidden until the next stored measurement. It then appears as a wrong value at the read port, up to N pulses later for an averaging count of N. A sequencer fault shows at once as a `busy` window that is not `NB` cycles long, or as a wrong buffer gaining a measurement.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  // averaging count as used by the datapath: zero behaves as one
  function automatic int unsigned bsa_avg_eff(int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // measurement limit as used by the datapath: clamped to capacity
  function automatic int unsigned bsa_meas_eff(int unsigned raw, int unsigned depth);
    return (raw == 0 || raw > depth) ? depth : raw;
  endfunction

  // flat address of slot ptr inside buffer bidx
  function automatic int unsigned bsa_slot_addr(int unsigned bidx, int unsigned ptr,
                                                int unsigned depth);
    return bidx * depth + ptr;
  endfunction

endpackage

// File: rtl/bsa_cfg_bank.sv
module bsa_cfg_bank #(
  parameter int NB    = 20,
  parameter int AW    = 8,
  parameter int PW    = 8,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_avg,
  input  logic [PW-1:0] cfg_meas,
  input  logic [IW-1:0] sel_idx,
  output logic [AW:0]   avg_eff,
  output logic [PW-1:0] meas_eff
);
  import bsa_pkg::*;

  logic [AW-1:0] avg_q  [NB];
  logic [PW-1:0] meas_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        avg_q[g]  <= '0;
        meas_q[g] <= '0;
      end else if (cfg_we && int'(cfg_idx) == g) begin
        avg_q[g]  <= cfg_avg;
        meas_q[g] <= cfg_meas;
      end
    end
  end

  always_comb begin
    avg_eff  = (AW+1)'(1);
    meas_eff = PW'(DEPTH);
    if (int'(sel_idx) < NB) begin
      avg_eff  = (AW+1)'(bsa_avg_eff(32'(avg_q[sel_idx])));
      meas_eff = PW'(bsa_meas_eff(32'(meas_q[sel_idx]), DEPTH));
    end
  end

endmodule

// File: rtl/bsa_sequencer.sv
module bsa_sequencer #(
  parameter int NB  = 20,
  parameter int DW  = 16,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [NB-1:0] smp_ev,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic [DW-1:0] data_q,
  output logic          ev_bit
);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  logic [NB-1:0] ev_q;
  logic          accept;
  logic          sweep_end;

  assign accept    = smp_valid && !busy;
  assign sweep_end = busy && (idx == LAST);
  assign ev_bit    = (int'(idx) < NB) ? ev_q[idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      data_q <= '0;
      ev_q   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      idx    <= '0;
      data_q <= smp_data;
      ev_q   <= smp_ev;
    end else if (sweep_end) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
    end
  end

  // the sweep ends after the last buffer
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_end |=> !busy);

  // a sample offered mid-sweep leaves the latched pulse untouched
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sweep_end) |=> $stable(data_q) && $stable(ev_q) && busy);

endmodule

// File: rtl/bsa_chan_state.sv
module bsa_chan_state #(
  parameter int NB    = 20,
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int PW    = 8,
  localparam int IW   = $clog2(NB),
  localparam int SW   = DW + AW,
  localparam int MAW  = $clog2(NB * DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act,
  input  logic [IW-1:0]   idx,
  input  logic [DW-1:0]   data_q,
  input  logic            ev_bit,
  input  logic [AW:0]     avg_eff,
  input  logic [PW-1:0]   meas_eff,
  input  logic [NB-1:0]   clr_mask,
  output logic            wr_en,
  output logic [MAW-1:0]  wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [NB*PW-1:0] fill_flat,
  output logic [NB-1:0]   done
);
  import bsa_pkg::*;

  logic [SW-1:0] sum_q [NB];
  logic [AW-1:0] cnt_q [NB];
  logic [PW-1:0] ptr_q [NB];
  logic [NB-1:0] done_q;

  logic          sel_ok;
  logic [SW-1:0] cur_sum, nsum, quot;
  logic [AW-1:0] cur_cnt;
  logic [AW:0]   ncnt;
  logic [PW-1:0] cur_ptr;
  logic          take, store, reach;

  always_comb begin
    sel_ok  = int'(idx) < NB;
    cur_sum = sel_ok ? sum_q[idx] : '0;
    cur_cnt = sel_ok ? cnt_q[idx] : '0;
    cur_ptr = sel_ok ? ptr_q[idx] : '0;
    take    = act && sel_ok && ev_bit && !done_q[idx] && !clr_mask[idx];
    nsum    = cur_sum + SW'(data_q);
    ncnt    = {1'b0, cur_cnt} + 1'b1;
    store   = take && (ncnt >= avg_eff);
    quot    = nsum / SW'(avg_eff);
    reach   = ({1'b0, cur_ptr} + 1'b1) >= {1'b0, meas_eff};
    wr_en   = store;
    wr_data = quot[DW-1:0];
    wr_addr = MAW'(bsa_slot_addr(32'(idx), 32'(cur_ptr), DEPTH));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (!rst_n || clr_mask[i]) begin
        sum_q[i]  <= '0;
        cnt_q[i]  <= '0;
        ptr_q[i]  <= '0;
        done_q[i] <= 1'b0;
      end else if (take && int'(idx) == i) begin
        if (store) begin
          sum_q[i]  <= '0;
          cnt_q[i]  <= '0;
          ptr_q[i]  <= cur_ptr + 1'b1;
          done_q[i] <= reach;
        end else begin
          sum_q[i] <= nsum;
          cnt_q[i] <= ncnt[AW-1:0];
        end
      end
    end
  end

  assign done = done_q;

  for (genvar g = 0; g < NB; g++) begin : g_chan
    assign fill_flat[g*PW +: PW] = ptr_q[g];

    assert_ptr_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q[g]) <= DEPTH);

    assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q[g] && !clr_mask[g]) |=> done_q[g] && $stable(ptr_q[g]));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[g] |=> (ptr_q[g] == '0) && !done_q[g] && (sum_q[g] == '0));

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(act && int'(idx) == g && ev_bit) && !clr_mask[g])
        |=> $stable(ptr_q[g]) && $stable(sum_q[g]) && $stable(done_q[g]));
  end

endmodule

// File: rtl/bsa_store.sv
module bsa_store #(
  parameter int WORDS = 2560,
  parameter int DW    = 16,
  localparam int MAW  = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [MAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // every write lands inside the array
  assert_waddr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(waddr) < WORDS);

endmodule

// File: rtl/bsa_fanout.sv
module bsa_fanout #(
  parameter int NB    = 20,
  parameter int DEPTH = 128,
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int PW    = 8,
  localparam int IW   = $clog2(NB),
  localparam int MAW  = $clog2(NB * DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [DW-1:0]    smp_data,
  input  logic [NB-1:0]    smp_ev,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [AW-1:0]    cfg_avg,
  input  logic [PW-1:0]    cfg_meas,
  input  logic [NB-1:0]    clr_mask,
  input  logic [IW-1:0]    rd_idx,
  input  logic [PW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [NB*PW-1:0] fill_cnt,
  output logic [NB-1:0]    done,
  output logic             busy
);
  import bsa_pkg::*;

  logic [IW-1:0]  seq_idx;
  logic [DW-1:0]  seq_data;
  logic           seq_ev;
  logic [AW:0]    avg_eff;
  logic [PW-1:0]  meas_eff;
  logic           wr_en;
  logic [MAW-1:0] wr_addr, rd_flat;
  logic [DW-1:0]  wr_data;

  assign rd_flat = MAW'(bsa_slot_addr(32'(rd_idx), 32'(rd_addr), DEPTH));

  bsa_sequencer #(.NB(NB), .DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ev(smp_ev), .busy(busy), .idx(seq_idx), .data_q(seq_data), .ev_bit(seq_ev)
  );

  bsa_cfg_bank #(.NB(NB), .AW(AW), .PW(PW), .DEPTH(DEPTH)) cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_avg(cfg_avg),
    .cfg_meas(cfg_meas), .sel_idx(seq_idx), .avg_eff(avg_eff), .meas_eff(meas_eff)
  );

  bsa_chan_state #(.NB(NB), .DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) chan_i (
    .clk(clk), .rst_n(rst_n), .act(busy), .idx(seq_idx), .data_q(seq_data),
    .ev_bit(seq_ev), .avg_eff(avg_eff), .meas_eff(meas_eff), .clr_mask(clr_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fill_flat(fill_cnt), .done(done)
  );

  bsa_store #(.WORDS(NB * DEPTH), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_flat), .rdata(rd_data)
  );

endmodule

// File: tb/bsa_fanout_tb_top.sv
module bsa_fanout_tb_top;
  localparam int NB = 20, DEPTH = 128, DW = 16, AW = 8, PW = 8;
  localparam int IW = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [NB-1:0] smp_ev = '0, clr_mask = '0, done;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0, rd_idx = '0;
  logic [AW-1:0] cfg_avg = '0;
  logic [PW-1:0] cfg_meas = '0, rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NB*PW-1:0] fill_cnt;
  logic busy;

  int checks = 0, errors = 0;
  int unsigned m_avg[NB], m_meas[NB], m_sum[NB], m_cnt[NB], m_ptr[NB];
  bit m_done[NB];
  int unsigned m_mem[NB][DEPTH];

  always #5 clk = ~clk;

  bsa_fanout #(.NB(NB), .DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data), .smp_ev(smp_ev),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_avg(cfg_avg), .cfg_meas(cfg_meas),
    .clr_mask(clr_mask), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_data(rd_data),
    .fill_cnt(fill_cnt), .done(done), .busy(busy));

  function automatic int unsigned ref_avg(int unsigned a);
    return (a < 1) ? 1 : a;
  endfunction
  function automatic int unsigned ref_meas(int unsigned m);
    if (m >= 1 && m <= DEPTH) return m;
    return DEPTH;
  endfunction
  function automatic int unsigned fill_of(int b);
    return fill_cnt[b*PW +: PW];
  endfunction

  task automatic chk(bit ok, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic model_pulse(int unsigned d, logic [NB-1:0] ev);
    for (int b = 0; b < NB; b++) begin
      if (ev[b] && !m_done[b]) begin
        m_sum[b] += d;
        m_cnt[b]++;
        if (m_cnt[b] == ref_avg(m_avg[b])) begin
          m_mem[b][m_ptr[b]] = m_sum[b] / ref_avg(m_avg[b]);
          m_ptr[b]++;
          m_sum[b] = 0;
          m_cnt[b] = 0;
          if (m_ptr[b] >= ref_meas(m_meas[b])) m_done[b] = 1;
        end
      end
    end
  endtask

  task automatic check_all(string tag);
    for (int b = 0; b < NB; b++) begin
      chk(fill_of(b) == m_ptr[b], {tag, " fill R2 R4"}, fill_of(b), m_ptr[b]);
      chk(done[b] == m_done[b], {tag, " done R4 R5"}, done[b], m_done[b]);
    end
  endtask

  task automatic set_cfg(int b, int unsigned a, int unsigned m);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(b); cfg_avg = AW'(a); cfg_meas = PW'(m);
    @(negedge clk);
    cfg_we = 0;
    m_avg[b] = a; m_meas[b] = m;
  endtask

  task automatic clear(logic [NB-1:0] m);
    @(negedge clk); clr_mask = m;
    @(negedge clk); clr_mask = '0;
    for (int b = 0; b < NB; b++)
      if (m[b]) begin
        m_sum[b] = 0; m_cnt[b] = 0; m_ptr[b] = 0; m_done[b] = 0;
        chk(fill_of(b) == 0 && !done[b], "clear R6", fill_of(b), 0);
      end
  endtask

  task automatic pulse(int unsigned d, logic [NB-1:0] ev, bit inject);
    int n = 0;
    @(negedge clk);
    smp_valid = 1; smp_data = DW'(d); smp_ev = ev;
    @(negedge clk);
    smp_valid = 0;
    while (busy && n < 100) begin
      if (inject && n == 3) begin
        smp_valid = 1; smp_data = '1; smp_ev = '1;
      end else smp_valid = 0;
      @(negedge clk);
      n++;
    end
    smp_valid = 0;
    chk(n == NB, "busy length R7", n, NB);
    model_pulse(d, ev);
    check_all("pulse");
  endtask

  task automatic rd(int b, int a, output int unsigned v);
    @(negedge clk); rd_idx = IW'(b); rd_addr = PW'(a);
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    summary();
  end

  initial begin
    int unsigned v;
    void'($urandom(32'd5150));
    for (int b = 0; b < NB; b++) begin
      m_avg[b] = 0; m_meas[b] = 0; m_sum[b] = 0; m_cnt[b] = 0; m_ptr[b] = 0; m_done[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "reset busy R1", busy, 0);
    chk(done == '0, "reset done R1", done, 0);
    chk(fill_cnt == '0, "reset fill R1", fill_of(0), 0);

    // per-buffer counts (R9)
    set_cfg(0, 3, 2);
    set_cfg(1, 0, 200);
    set_cfg(2, 1, 5);
    set_cfg(3, 2, 5);
    for (int b = 4; b < NB; b++) set_cfg(b, $urandom_range(0, 4), $urandom_range(1, 12));

    // R3: mean of 10,20,33 is 21; the injected sample must be ignored (R7)
    pulse(10, 20'h00001, 1);
    pulse(20, 20'h00001, 0);
    pulse(33, 20'h00001, 1);
    rd(0, 0, v);
    chk(v == 21, "average R3 R8", v, 21);
    chk(fill_of(2) == 0, "gated buffer R2", fill_of(2), 0);

    // R6: partial sum dropped by clear, next pair averages to 50
    pulse(100, 20'h00008, 0);
    clear(20'h00008);
    pulse(40, 20'h00008, 0);
    pulse(60, 20'h00008, 0);
    rd(3, 0, v);
    chk(v == 50, "clear drops sum R6", v, 50);

    // random pulses; buffer 1 always gated on to reach capacity
    for (int p = 0; p < 160; p++) begin
      pulse($urandom_range(0, 65535), NB'($urandom) | 20'h00002, (p % 7) == 0);
      if (p % 16 == 15) clear(NB'($urandom) & ~20'h00002 & ~20'h00001);
    end
    chk(fill_of(1) == DEPTH, "capacity R5", fill_of(1), DEPTH);
    chk(done[1] == 1, "capacity done R5", done[1], 1);
    chk(fill_of(0) == 2 && done[0], "measurement limit R4", fill_of(0), 2);

    for (int b = 0; b < NB; b++)
      for (int a = 0; a < int'(m_ptr[b]); a++) begin
        rd(b, a, v);
        chk(v == m_mem[b][a], "readback R8", v, m_mem[b][a]);
      end
    summary();
  end
endmodule